// File: doc/BRIEF.md
# Column-Order Digit Product Engine

This block forms the full product of two unsigned multi-digit integers whose 16-bit digits sit in two operand memories, least significant digit at address 0. One single-cycle 16x16 multiplier feeds a 50-bit accumulator. The engine sums every digit product of one output column (all pairs whose indices add up to the column number), starting with the lowest column. When a column closes, the low digit of the accumulator goes straight to a separate result memory and the accumulator moves down by one digit. Partial products are therefore never stored.

A squaring mode computes each symmetric cross product once, adds it in doubled, and adds each square term once. This takes about half the multiplier cycles of a general product. A one-cycle start request launches an operation with the operand lengths on the length inputs. The engine issues one read address per clock to each operand bank and one write per column to the result bank, then pulses done. The operand banks are read with one cycle of latency, as an inferred block RAM behaves.

Top module: `cmac_engine`

## Requirements
- R1: In general mode (`square` = 0), after done the result bank holds A·B with result digit k at address k, for len_a + len_b digits. Operand digit i is read from address i of its bank.
- R2: During one operation each result address is written exactly once, in ascending order starting at address 0. There are len_a + len_b writes in general mode and 2·len_a writes in squaring mode.
- R3: In general mode, done is high exactly len_a·len_b + 4 clock cycles after the clock edge that accepts start, which is one multiplier cycle per digit product.
- R4: In squaring mode (`square` = 1), the result is A·A over 2·len_a digits. The operand must be loaded at the same addresses in both operand banks.
- R5: In squaring mode, done is high exactly len_a·(len_a+1)/2 + 4 cycles after the accepting edge.
- R6: done is high for a single cycle, and no result write happens in that cycle. busy is high from the accepting edge until done rises, and it is low in the done cycle.
- R7: A start request while busy is high is ignored: the result and the timing of the running operation stay unchanged.
- R8: After reset, busy, done and the result write enable are low.
- R9: With every digit at 0xFFFF and both lengths at the maximum, the result is exact, and the accumulator does not lose a carry.
- R10: Single-digit operands and unequal lengths in either order give the exact product.
- R11: In squaring mode, len_b has no effect on the result or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, taken when busy is low |
| square | input | 1 | 1 selects squaring of operand A |
| len_a | input | LW | Digit count of A (1..MAXD) |
| len_b | input | LW | Digit count of B (1..MAXD), unused when squaring |
| a_addr | output | IW | Read address of operand bank A |
| a_rdata | input | DW | Digit from bank A, one cycle after its address |
| b_addr | output | IW | Read address of operand bank B |
| b_rdata | input | DW | Digit from bank B, one cycle after its address |
| r_we | output | 1 | Result bank write enable |
| r_addr | output | CW | Result bank write address |
| r_wdata | output | DW | Result digit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume several things about the inputs:
- len_a and len_b lie between 1 and MAXD and stay steady in the cycle where start is accepted.
- Start comes only from reset-free operation.
- The operand banks answer a read address with its data on the next clock.

The bench drives the lengths and the mode together with start on a falling edge and only uses legal lengths. Its bank model gives registered reads. For squaring it loads the same digits into both banks. The timing and write-order checks count from the accepting edge, so the bench also sends a stray start mid-run to show that the counts do not restart.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
  localparam int DIG_W  = 16;
  localparam int ACC_W  = 50;
  localparam int MAX_DG = 16;

  function automatic int idx_bits(input int depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/cmac_seq.sv
module cmac_seq #(
  parameter int MAXD = 16,
  localparam int IW = cmac_pkg::idx_bits(MAXD),
  localparam int CW = cmac_pkg::idx_bits(2 * MAXD),
  localparam int LW = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          sq_in,
  input  logic [LW-1:0] len_a,
  input  logic [LW-1:0] len_b,
  output logic [IW-1:0] a_addr,
  output logic [IW-1:0] b_addr,
  output logic          t_vld,
  output logic          t_last,
  output logic          t_fin,
  output logic          t_dbl,
  output logic [CW-1:0] t_col
);
  typedef logic [CW-1:0] col_t;

  logic          running;
  logic          sq;
  logic [LW-1:0] la, lb;
  col_t          k, i;
  col_t          lbe, kmax, hi, j, knext, lo_next;
  logic          col_end, op_end;

  // Effective B length: squaring pairs A with itself
  always_comb begin
    lbe     = sq ? col_t'(la) : col_t'(lb);
    kmax    = col_t'(la) + lbe - col_t'(2);
    j       = k - i;
    if (sq) hi = k >> 1;
    else    hi = (k < col_t'(la)) ? k : col_t'(la) - col_t'(1);
    knext   = k + col_t'(1);
    lo_next = (knext >= lbe) ? knext - lbe + col_t'(1) : '0;
    col_end = (i == hi);
    op_end  = col_end && (k == kmax);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      sq      <= 1'b0;
      la      <= '0;
      lb      <= '0;
      k       <= '0;
      i       <= '0;
      a_addr  <= '0;
      b_addr  <= '0;
      t_vld   <= 1'b0;
      t_last  <= 1'b0;
      t_fin   <= 1'b0;
      t_dbl   <= 1'b0;
      t_col   <= '0;
    end else begin
      t_vld  <= 1'b0;
      t_last <= 1'b0;
      t_fin  <= 1'b0;
      if (!running) begin
        if (go) begin
          running <= 1'b1;
          sq      <= sq_in;
          la      <= len_a;
          lb      <= len_b;
          k       <= '0;
          i       <= '0;
        end
      end else begin
        t_vld  <= 1'b1;
        a_addr <= IW'(i);
        b_addr <= IW'(j);
        t_dbl  <= sq && (i != j);
        t_col  <= k;
        t_last <= col_end;
        t_fin  <= op_end;
        if (col_end) begin
          if (op_end) begin
            running <= 1'b0;
          end else begin
            k <= knext;
            i <= lo_next;
          end
        end else begin
          i <= i + col_t'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cmac_mul.sv
module cmac_mul #(
  parameter int DW = 16,
  localparam int PW = 2 * DW + 1
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          dbl,
  output logic [PW-1:0] p
);
  logic [2*DW-1:0] raw;

  always_comb begin
    raw = x * y;
    p   = dbl ? {raw, 1'b0} : {1'b0, raw};
  end
endmodule

// File: rtl/cmac_acc.sv
module cmac_acc #(
  parameter int DW = 16,
  parameter int AW = 50,
  parameter int CW = 5,
  localparam int PW = 2 * DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          vld,
  input  logic          last,
  input  logic          fin,
  input  logic [CW-1:0] col,
  input  logic [PW-1:0] ext,
  output logic          r_we,
  output logic [CW-1:0] r_addr,
  output logic [DW-1:0] r_wdata,
  output logic          ending,
  output logic          done
);
  logic [AW-1:0] acc, sum;
  logic          pend;
  logic [CW-1:0] top;

  assign sum = acc + AW'(ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      r_we    <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      pend    <= 1'b0;
      top     <= '0;
      ending  <= 1'b0;
      done    <= 1'b0;
    end else begin
      r_we   <= 1'b0;
      done   <= ending;
      ending <= 1'b0;
      if (clr) acc <= '0;
      if (vld) begin
        if (last) begin
          r_we    <= 1'b1;
          r_addr  <= col;
          r_wdata <= sum[DW-1:0];
          acc     <= sum >> DW;
        end else begin
          acc <= sum;
        end
        if (fin) begin
          pend <= 1'b1;
          top  <= col + CW'(1);
        end
      end
      if (pend) begin
        r_we    <= 1'b1;
        r_addr  <= top;
        r_wdata <= acc[DW-1:0];
        acc     <= '0;
        pend    <= 1'b0;
        ending  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmac_engine.sv
module cmac_engine #(
  parameter int MAXD = cmac_pkg::MAX_DG,
  parameter int DW   = cmac_pkg::DIG_W,
  parameter int AW   = cmac_pkg::ACC_W,
  localparam int IW = cmac_pkg::idx_bits(MAXD),
  localparam int CW = cmac_pkg::idx_bits(2 * MAXD),
  localparam int LW = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          square,
  input  logic [LW-1:0] len_a,
  input  logic [LW-1:0] len_b,
  output logic [IW-1:0] a_addr,
  input  logic [DW-1:0] a_rdata,
  output logic [IW-1:0] b_addr,
  input  logic [DW-1:0] b_rdata,
  output logic          r_we,
  output logic [CW-1:0] r_addr,
  output logic [DW-1:0] r_wdata,
  output logic          busy,
  output logic          done
);
  localparam int PW = 2 * DW + 1;

  logic          go;
  logic          s1_vld, s1_last, s1_fin, s1_dbl;
  logic [CW-1:0] s1_col;
  logic          s2_vld, s2_last, s2_fin, s2_dbl;
  logic [CW-1:0] s2_col;
  logic [PW-1:0] prod;
  logic          ending;

  assign go = start && !busy;

  cmac_seq #(.MAXD(MAXD)) u_seq (
    .clk(clk), .rst(rst), .go(go), .sq_in(square),
    .len_a(len_a), .len_b(len_b),
    .a_addr(a_addr), .b_addr(b_addr),
    .t_vld(s1_vld), .t_last(s1_last), .t_fin(s1_fin),
    .t_dbl(s1_dbl), .t_col(s1_col)
  );

  // Tags follow the read addresses through the bank latency
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld  <= 1'b0;
      s2_last <= 1'b0;
      s2_fin  <= 1'b0;
      s2_dbl  <= 1'b0;
      s2_col  <= '0;
    end else begin
      s2_vld  <= s1_vld;
      s2_last <= s1_last;
      s2_fin  <= s1_fin;
      s2_dbl  <= s1_dbl;
      s2_col  <= s1_col;
    end
  end

  cmac_mul #(.DW(DW)) u_mul (
    .x(a_rdata), .y(b_rdata), .dbl(s2_dbl), .p(prod)
  );

  cmac_acc #(.DW(DW), .AW(AW), .CW(CW)) u_acc (
    .clk(clk), .rst(rst), .clr(go),
    .vld(s2_vld), .last(s2_last), .fin(s2_fin), .col(s2_col),
    .ext(prod),
    .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .ending(ending), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst)         busy <= 1'b0;
    else if (go)     busy <= 1'b1;
    else if (ending) busy <= 1'b0;
  end
endmodule

// File: rtl/cmac_chk.sv
module cmac_chk #(
  parameter int MAXD = 16,
  parameter int DW   = 16,
  localparam int CW = cmac_pkg::idx_bits(2 * MAXD),
  localparam int LW = $clog2(MAXD + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          square,
  input logic [LW-1:0] len_a,
  input logic [LW-1:0] len_b,
  input logic          r_we,
  input logic [CW-1:0] r_addr,
  input logic [DW-1:0] r_wdata,
  input logic          busy,
  input logic          done
);
  logic armed;
  int   cyc, nxt, expn, expw;
  logic wd_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      cyc     <= 0;
      nxt     <= 0;
      expn    <= 0;
      expw    <= 0;
      wd_seen <= 1'b0;
    end else if (start && !busy) begin
      armed <= 1'b1;
      cyc   <= 0;
      nxt   <= 0;
      if (square) begin
        expn <= int'(len_a) * (int'(len_a) + 1) / 2;
        expw <= 2 * int'(len_a);
      end else begin
        expn <= int'(len_a) * int'(len_b);
        expw <= int'(len_a) + int'(len_b);
      end
    end else begin
      cyc <= cyc + 1;
      if (r_we) begin
        nxt     <= nxt + 1;
        wd_seen <= wd_seen | (r_wdata != '0);
      end
    end
  end

  assert_write_order_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && r_we) |-> (int'(r_addr) == nxt));

  assert_write_count_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && done) |-> (nxt == expw));

  // covers R5 as well: expn holds the squaring product count
  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && done) |-> (cyc == expn + 4));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_no_write_at_done_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !r_we);

  assert_write_busy_R6: assert property (@(posedge clk) disable iff (rst)
    r_we |-> busy);

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!busy && !done && !r_we));
endmodule

bind cmac_engine cmac_chk #(.MAXD(MAXD), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .square(square),
  .len_a(len_a), .len_b(len_b), .r_we(r_we), .r_addr(r_addr),
  .r_wdata(r_wdata), .busy(busy), .done(done)
);

// File: tb/cmac_engine_test.sv
module cmac_engine_test;
  localparam int MAXD = 16;
  localparam int DW   = 16;
  localparam int IW   = 4;
  localparam int CW   = 5;
  localparam int LW   = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          square = 1'b0;
  logic [LW-1:0] len_a = '0, len_b = '0;
  logic [IW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_rdata, b_rdata;
  logic          r_we, busy, done;
  logic [CW-1:0] r_addr;
  logic [DW-1:0] r_wdata;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] memA [MAXD];
  logic [DW-1:0] memB [MAXD];
  logic [DW-1:0] memR [2*MAXD];
  int wcount;
  bit worder_bad;
  longint unsigned expr [2*MAXD];
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  cmac_engine #(.MAXD(MAXD)) uut (
    .clk(clk), .rst(rst), .start(start), .square(square),
    .len_a(len_a), .len_b(len_b),
    .a_addr(a_addr), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_rdata(b_rdata),
    .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    a_rdata <= memA[a_addr];
    b_rdata <= memB[b_addr];
    if (r_we) begin
      memR[r_addr] <= r_wdata;
      if (int'(r_addr) != wcount) worder_bad = 1;
      wcount = wcount + 1;
    end
  end

  function automatic logic [DW-1:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[DW-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // 0 = random, 1 = all ones
  task automatic load(input int la, input int lb, input bit sq, input int pat);
    for (int x = 0; x < MAXD; x++) begin
      memA[x] = (pat == 1) ? 16'hFFFF : rnd();
      memB[x] = (pat == 1) ? 16'hFFFF : rnd();
      if (sq) memB[x] = memA[x];
    end
    for (int x = 0; x < 2*MAXD; x++) begin
      memR[x] = 16'hDEAD;
      expr[x] = 0;
    end
    // row-order reference product
    for (int x = 0; x < la; x++) begin
      longint unsigned carry = 0;
      int lbe = sq ? la : lb;
      for (int y = 0; y < lbe; y++) begin
        longint unsigned t = expr[x+y] + longint'(memA[x]) * longint'(sq ? memA[y] : memB[y]) + carry;
        expr[x+y] = t & 64'hFFFF;
        carry = t >> 16;
      end
      expr[x+lbe] = carry;
    end
  endtask

  task automatic run_op(input int la, input int lb, input bit sq, input int pat,
                        input bit poke, input string rq_val, input string rq_lat);
    int cyc = 0;
    int nprod = sq ? la * (la + 1) / 2 : la * lb;
    int nw = sq ? 2 * la : la + lb;
    bit bad = 0;
    bit busy_seen = 0;
    int badk = 0;
    load(la, lb, sq, pat);
    @(negedge clk);
    wcount = 0;
    worder_bad = 0;
    len_a = LW'(la);
    len_b = LW'(lb);
    square = sq;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_seen = busy;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      start = (poke && cyc == 2);
      if (poke && cyc == 3) begin
        len_a = LW'(1);
        len_b = LW'(1);
        square = ~sq;
      end
    end
    start = 1'b0;
    for (int x = 0; x < nw; x++)
      if (!bad && longint'(memR[x]) != expr[x]) begin
        bad = 1;
        badk = x;
      end
    check(!bad, rq_val, "result digit", longint'(memR[badk]), longint'(expr[badk]));
    check(cyc == nprod + 4, rq_lat, "done latency", cyc, nprod + 4);
    check(wcount == nw && !worder_bad, "R2", "write count/order", wcount, nw);
    check(busy_seen && !busy, "R6", "busy window", busy, 0);
    @(negedge clk);
    check(!done && !r_we, "R6", "done single pulse", done, 0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !r_we, "R8", "reset outputs", {busy, done, r_we}, 0);
  endtask

  task automatic t_general();
    run_op(4, 4, 0, 0, 0, "R1", "R3");
    run_op(1, 1, 0, 0, 0, "R10", "R3");
    run_op(3, 7, 0, 0, 0, "R10", "R3");
    run_op(16, 1, 0, 0, 0, "R10", "R3");
    run_op(16, 16, 0, 1, 0, "R9", "R3");
  endtask

  task automatic t_square();
    run_op(5, 5, 1, 0, 0, "R4", "R5");
    run_op(1, 1, 1, 1, 0, "R4", "R5");
    run_op(16, 16, 1, 1, 0, "R9", "R5");
    run_op(6, 2, 1, 0, 0, "R11", "R11");
  endtask

  task automatic t_poke();
    run_op(5, 6, 0, 0, 1, "R7", "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_general();
    t_square();
    t_poke();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule